// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides when a timer counter may advance. It produces a single-cycle tick that the counter uses as its increment enable. A 3-bit select field picks the tick source: none (timer halted), every system clock, the system clock divided by 8, 64, 256 or 1024, or the rising or falling edges of an external clock pin.

All divided rates come from one shared 10-bit prescale counter that runs freely from reset. A clear input returns that counter to zero so that a divided period can start at a known moment. The external pin passes through a two-flop synchronizer and an edge detector, so one tick follows each qualifying pin edge after a fixed delay. The tick is registered, and a new select value takes effect on the clock after it is presented.

Top module: `tmr_tick_sel`

## Requirements
- R1: While reset is asserted and after its release, `tick_o` is 0. The prescale counter and the pin synchronizer start from zero.
- R2: Select code 000 produces no tick, whatever the external pin or the prescale counter does.
- R3: Select code 001 makes `tick_o` high in every cycle. `tick_o` follows the select value one clock after the clock edge at which it is sampled.
- R4: Select codes 010, 011, 100 and 101 give one tick every 8, 64, 256 and 1024 clocks respectively. The tick is high in the cycle after the low 3, 6, 8 or 10 bits of the free-running 10-bit prescale counter are all ones.
- R5: Suppose `psr_clr_i` is high at a clock edge and a divided code with ratio N is then selected. The counter is zero after that edge, and the first tick appears in the cycle after the N-th following clock edge.
- R6: Select code 111 produces one tick for each rising edge of `ext_clk_i`. If the pin changes before clock edge E0, `tick_o` is high after edge E2 only.
- R7: Select code 110 produces one tick for each falling edge of `ext_clk_i`, with the same delay as R6. Rising edges produce no tick.
- R8: Changing the select field produces no tick by itself. Switching to an external-pin code while the pin is steady gives no tick.
- R9: Each detected pin edge gives a tick exactly one cycle long. Pin levels must be held for at least two system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_i | input | 3 | Tick source select code |
| ext_clk_i | input | 1 | External clock pin, asynchronous to clk_i |
| psr_clr_i | input | 1 | Synchronous clear of the prescale counter |
| tick_o | output | 1 | One-cycle count-enable tick |

## Verification
The assertions on the edge detector assume that the external pin holds each level for at least two system clocks. Faster edges are allowed to merge, and a one-cycle pulse would no longer be guaranteed. The stimulus holds every pin level for six clocks or more and changes the pin and the select field only at falling clock edges. The prescale assertions take `psr_clr_i` as a plain synchronous input, and the bench pulses it with the selector parked at code 000 so that no stray tick can fall inside a measured window.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

  localparam int SEL_W  = 3;
  localparam int PSC_W  = 10;
  localparam int N_TAPS = 4;

  typedef enum logic [SEL_W-1:0] {
    TS_STOP     = 3'b000,
    TS_DIV1     = 3'b001,
    TS_DIV8     = 3'b010,
    TS_DIV64    = 3'b011,
    TS_DIV256   = 3'b100,
    TS_DIV1024  = 3'b101,
    TS_EXT_FALL = 3'b110,
    TS_EXT_RISE = 3'b111
  } tmr_sel_e;

  // log2 of each divided ratio, index 0 = smallest ratio
  function automatic int tap_log2(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_tick_pkg::*;
#(
  parameter int CNT_W = PSC_W,
  parameter int TAPS  = N_TAPS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  output logic [TAPS-1:0] tap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    localparam int LW = tap_log2(g);
    assign tap_o[g] = &cnt_q[LW-1:0];

    // R4: every divided tap is a one-cycle strobe
    p_tap_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tap_o[g] |=> !tap_o[g]);
  end

  // R5: clear returns the counter to zero
  p_clr_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

  // R4: free-running advance by one per clock
  p_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/tmr_ext_edge.sv
module tmr_ext_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;
  logic              lvl;

  if (STAGES > 1) begin : g_chain
    assign sync_d = {sync_q[STAGES-2:0], pin_i};
  end else begin : g_single
    assign sync_d = pin_i;
  end

  assign lvl    = sync_q[STAGES-1];
  assign prev_d = lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = lvl & ~prev_q;
  assign fall_o = ~lvl & prev_q;

  // R9: one detected edge gives a single-cycle strobe
  p_rise_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  p_fall_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
  // R6, R7: rising and falling strobes never coincide
  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));

endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_tick_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_clk_i,
  input  logic             psr_clr_i,
  output logic             tick_o
);

  logic [N_TAPS-1:0] tap_w;
  logic              rise_w;
  logic              fall_w;
  logic              tick_d;
  logic              tick_q;
  tmr_sel_e          sel_e;

  tmr_prescale #(
    .CNT_W (PSC_W),
    .TAPS  (N_TAPS)
  ) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (psr_clr_i),
    .tap_o  (tap_w)
  );

  tmr_ext_edge #(
    .STAGES (SYNC_STAGES)
  ) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_clk_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  assign sel_e = tmr_sel_e'(sel_i);

  always_comb begin
    tick_d = 1'b0;
    case (sel_e)
      TS_STOP:     tick_d = 1'b0;
      TS_DIV1:     tick_d = 1'b1;
      TS_DIV8:     tick_d = tap_w[0];
      TS_DIV64:    tick_d = tap_w[1];
      TS_DIV256:   tick_d = tap_w[2];
      TS_DIV1024:  tick_d = tap_w[3];
      TS_EXT_FALL: tick_d = fall_w;
      TS_EXT_RISE: tick_d = rise_w;
      default:     tick_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R1: output low while in reset
  p_rst_low_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !tick_o);
  // R2: stop code gives no tick on the following cycle
  p_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b000) |=> !tick_o);
  // R3: undivided code ticks on the following cycle
  p_div1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b001) |=> tick_o);
  // R7: falling-edge code ignores rising pin strobes
  p_fall_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel_i == 3'b110) && rise_w) |=> !tick_o);

endmodule

// File: tb/tmr_tick_sel_tb_top.sv
module tmr_tick_sel_tb_top;

  localparam int NV = 6;
  localparam int WIN = 2048;
  localparam logic [2:0] VEC_SEL   [NV] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101};
  localparam int         VEC_FIRST [NV] = '{-1, 0, 7, 63, 255, 1023};
  localparam int         VEC_CNT   [NV] = '{0, 2048, 256, 32, 8, 2};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       ext = 1'b0;
  logic       clr = 1'b0;
  logic       tick;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tmr_tick_sel dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sel_i     (sel),
    .ext_clk_i (ext),
    .psr_clr_i (clr),
    .tick_o    (tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count ticks over n samples taken at falling edges
  task automatic count_ticks(input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
  endtask

  task automatic pin_periods(input int n, input int hold);
    for (int k = 0; k < n; k++) begin
      ext = 1'b1;
      repeat (hold) @(negedge clk);
      ext = 1'b0;
      repeat (hold) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    int first;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 tick low in reset", int'(tick), 0);
    rst_n = 1'b1;
    count_ticks(4, c);
    chk("R1 no tick after reset release", c, 0);

    // table walk: R2, R3, R4, R5
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      sel = 3'b000;
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      sel = VEC_SEL[v];
      c = 0;
      first = -1;
      for (int j = 0; j < WIN; j++) begin
        @(negedge clk);
        if (tick) begin
          if (first < 0) first = j;
          c++;
        end
      end
      chk($sformatf("R4 tick count code %0d", VEC_SEL[v]), c, VEC_CNT[v]);
      chk($sformatf("R5 first tick after clear code %0d", VEC_SEL[v]), first, VEC_FIRST[v]);
    end

    // R3: select change latency to and from code 001
    @(negedge clk);
    sel = 3'b000;
    @(negedge clk);
    sel = 3'b001;
    @(negedge clk);
    chk("R3 tick one clock after select", int'(tick), 1);
    sel = 3'b000;
    @(negedge clk);
    chk("R2 tick stops one clock after stop code", int'(tick), 0);

    // R2: pin activity ignored in stop mode
    sel = 3'b000;
    ext = 1'b0;
    repeat (4) @(negedge clk);
    fork
      pin_periods(5, 6);
      count_ticks(64, c);
    join
    chk("R2 stop ignores pin edges", c, 0);

    // R6: latency from pin change to tick
    sel = 3'b111;
    ext = 1'b0;
    repeat (4) @(negedge clk);
    ext = 1'b1;
    @(negedge clk); chk("R6 no tick after E0", int'(tick), 0);
    @(negedge clk); chk("R6 no tick after E1", int'(tick), 0);
    @(negedge clk); chk("R6 tick after E2", int'(tick), 1);
    @(negedge clk); chk("R9 tick is one cycle", int'(tick), 0);
    ext = 1'b0;
    repeat (6) @(negedge clk);

    // R6: rising edges counted
    fork
      pin_periods(5, 6);
      count_ticks(66, c);
    join
    chk("R6 one tick per rising edge", c, 5);

    // R7: falling edges counted, rising ignored
    sel = 3'b110;
    repeat (4) @(negedge clk);
    fork
      pin_periods(5, 7);
      count_ticks(76, c);
    join
    chk("R7 one tick per falling edge", c, 5);

    // R7: a rise alone gives nothing in falling mode
    ext = 1'b0;
    repeat (6) @(negedge clk);
    ext = 1'b1;
    count_ticks(8, c);
    chk("R7 rising edge ignored", c, 0);

    // R8: switching mode with steady pin gives no tick
    sel = 3'b000;
    repeat (6) @(negedge clk);
    sel = 3'b111;
    count_ticks(10, c);
    chk("R8 no tick from select change (high pin)", c, 0);
    sel = 3'b110;
    count_ticks(10, c);
    chk("R8 no tick from rise-to-fall switch", c, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule